// File: doc/BRIEF.md
# Hot-Plug Detect Conditioner with Interrupt Register Block

This block takes two raw, asynchronous cable-presence signals, a hot-plug detect line and a receiver-sense line, and turns each one into a clean filtered level. First each signal is synchronized. Then a short-pulse rejector removes spikes of up to N cycles. Finally a persistence qualifier accepts a new level only after it has stayed unchanged for more than M × 2^VALID_SHIFT cycles. With the default VALID_SHIFT of 10, that is M × 1024 cycles. Both N and M are set by software through a configuration register.

Each change of a filtered level raises a sticky rise or fall flag in a pending register. A core interrupt input from a neighbouring controller also feeds the same pending register. Software can set any implemented flag by hand and can clear flags through a separate write-one-to-clear register. An enable register, where 1 means enabled, selects which pending flags drive the single interrupt line. The registers sit behind a simple single-cycle register port: writes take effect on the clock edge, and reads return data combinationally.

Top module: `hpd_intr_filter`

## Requirements
- R1: After reset, every register reads zero, both filtered levels are low, and `irq_out` is low.
- R2: Each raw input passes through two synchronizing flops. A pulse lasting N cycles or fewer after synchronization never reaches the filtered level, where N is configuration bits 15:12.
- R3: A level surviving the glitch stage becomes the filtered level only after it persists for more than M × 2^VALID_SHIFT cycles, where M is configuration bits 11:0. Word 4 reads the filtered hot-plug level in bit 0 and the filtered receiver-sense level in bit 1. With the signal driven before clock edge 1, the filtered level changes at edge 4 + N + M × 2^VALID_SHIFT.
- R4: A filtered low-to-high change sets pending bit 1 (hot-plug) or bit 6 (receiver sense). A high-to-low change sets bit 2 or bit 7. The flags stay set until cleared.
- R5: While `core_irq_in` is high, pending bit 0 is set on each clock edge.
- R6: Writing word 2 with a 1 in an implemented bit (0, 1, 2, 6, 7) sets that pending bit. The other bits always read zero.
- R7: Writing word 3 with a 1 in a bit clears that pending bit. Word 3 always reads zero.
- R8: If a hardware set event and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R9: `irq_out` is high exactly when some pending bit is also set in the enable register (word 1, same bit positions). Unimplemented enable bits read zero.
- R10: Word 0 is the filter configuration and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hpd_raw | input | 1 | Unsynchronized hot-plug detect line |
| rxsense_raw | input | 1 | Unsynchronized receiver-sense line |
| core_irq_in | input | 1 | Level interrupt request from the controller core |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with VALID_SHIFT = 2, so one step of M is 4 cycles instead of 1024. This keeps every persistence threshold, from M = 0 up to several steps, within a few dozen cycles. It lets a single table sweep pulse widths just below and just above both the glitch bound and the persistence bound, and it lets the exact cycle of a filtered-level change be observed. With these values, the ordering of the two stages, the off-by-one edge of the "more than" comparisons, and collisions between set and clear can all be reached in a short run.

// File: rtl/hpd_intr_pkg.sv
// Package: shared constants for the hot-plug conditioner.
// Holds the register word addresses, the field widths and the interrupt bit positions.
package hpd_intr_pkg;
    localparam int BUS_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int GLITCH_W  = 4;
    localparam int VALID_W   = 12;
    localparam int IRQ_W     = 8;
    localparam int NUM_LINES = 2;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd4;

    localparam int B_CORE    = 0;
    localparam int B_HPD_R   = 1;
    localparam int B_HPD_F   = 2;
    localparam int B_RXS_R   = 6;
    localparam int B_RXS_F   = 7;

    localparam logic [IRQ_W-1:0] IMPL_MASK = 8'hC7;
endpackage

// File: rtl/hpd_sync2.sv
// Module: two-flop synchronizer.
// Brings one asynchronous level into the clk domain.
// Assumes the input changes slowly compared with clk.
module hpd_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/hpd_level_qualifier.sv
// Module: synchronizer, short-pulse rejector and persistence qualifier for one line.
// Stage 1 adopts a synchronized level after it differs for glitch_n+1 cycles.
// Stage 2 adopts that level after it differs for (valid_m << VALID_SHIFT)+1 cycles.
// rise_o and fall_o pulse on the same edge that level_o changes.
// Assumes the configuration is static while a transition is qualifying.
module hpd_level_qualifier #(
    parameter int GLITCH_W    = 4,
    parameter int VALID_W     = 12,
    parameter int VALID_SHIFT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_in,
    input  logic [GLITCH_W-1:0] glitch_n,
    input  logic [VALID_W-1:0]  valid_m,
    output logic                level_o,
    output logic                rise_o,
    output logic                fall_o
);
    localparam int VCNT_W = VALID_W + VALID_SHIFT;

    logic                synced;
    logic                deglitched_q;
    logic [GLITCH_W-1:0] gcnt_q;
    logic [VCNT_W-1:0]   vcnt_q;
    logic [VCNT_W-1:0]   vlimit;

    hpd_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    assign vlimit = {valid_m, {VALID_SHIFT{1'b0}}};

    // Glitch stage: count the cycles of disagreement and adopt after glitch_n+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deglitched_q <= 1'b0;
            gcnt_q       <= '0;
        end else if (synced == deglitched_q) begin
            gcnt_q <= '0;
        end else if (gcnt_q == glitch_n) begin
            deglitched_q <= synced;
            gcnt_q       <= '0;
        end else begin
            gcnt_q <= gcnt_q + 1'b1;
        end
    end

    // Persistence stage: adopt after more than the scaled valid width and flag the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= 1'b0;
            vcnt_q  <= '0;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (deglitched_q == level_o) begin
                vcnt_q <= '0;
            end else if (vcnt_q == vlimit) begin
                level_o <= deglitched_q;
                vcnt_q  <= '0;
                rise_o  <= deglitched_q;
                fall_o  <= !deglitched_q;
            end else begin
                vcnt_q <= vcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hpd_irq_regs.sv
// Module: configuration, enable, pending and clear registers, plus the interrupt line.
// Hardware events and software sets take priority over clears within the same cycle.
// Reads are combinational from bus_addr.
module hpd_irq_regs
    import hpd_intr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic [IRQ_W-1:0]      hw_evt,
    input  logic [NUM_LINES-1:0]  levels,
    output logic [GLITCH_W-1:0]   glitch_n,
    output logic [VALID_W-1:0]    valid_m,
    output logic [IRQ_W-1:0]      pending,
    output logic [IRQ_W-1:0]      enable,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  irq_out
);
    logic [BUS_W-1:0] cfg_q;
    logic [IRQ_W-1:0] sw_set;
    logic [IRQ_W-1:0] sw_clr;
    logic [IRQ_W-1:0] pend_nxt;

    assign glitch_n = cfg_q[15:12];
    assign valid_m  = cfg_q[11:0];

    // Decode software set and clear strobes and form the next pending value.
    always_comb begin
        sw_set   = (bus_wr && bus_addr == A_PEND)  ? bus_wdata[IRQ_W-1:0] : '0;
        sw_clr   = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata[IRQ_W-1:0] : '0;
        pend_nxt = ((pending & ~sw_clr) | sw_set | hw_evt) & IMPL_MASK;
    end

    // Register updates for configuration, enable and pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            enable  <= '0;
            pending <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CFG)    cfg_q  <= bus_wdata;
            if (bus_wr && bus_addr == A_ENABLE) enable <= bus_wdata[IRQ_W-1:0] & IMPL_MASK;
            pending <= pend_nxt;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:    bus_rdata = cfg_q;
            A_ENABLE: bus_rdata[IRQ_W-1:0] = enable;
            A_PEND:   bus_rdata[IRQ_W-1:0] = pending;
            A_LEVEL:  bus_rdata[NUM_LINES-1:0] = levels;
            default:  bus_rdata = '0;
        endcase
    end

    // Combine the enabled pending flags onto one line.
    assign irq_out = |(pending & enable);
endmodule

// File: rtl/hpd_intr_filter.sv
// Module: top level of the hot-plug conditioner.
// Instantiates one qualifier per line (line 0 is hot-plug, line 1 is receiver sense)
// and maps their edge flags and the core request onto the pending bit positions.
// Assumes core_irq_in is already synchronous to clk.
module hpd_intr_filter
    import hpd_intr_pkg::*;
#(
    parameter int VALID_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_raw,
    input  logic              rxsense_raw,
    input  logic              core_irq_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_out
);
    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] fall;
    logic [GLITCH_W-1:0]  glitch_n;
    logic [VALID_W-1:0]   valid_m;
    logic [IRQ_W-1:0]     hw_evt;
    logic [IRQ_W-1:0]     pending;
    logic [IRQ_W-1:0]     enable;

    assign raw_vec = {rxsense_raw, hpd_raw};

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        hpd_level_qualifier #(
            .GLITCH_W    (GLITCH_W),
            .VALID_W     (VALID_W),
            .VALID_SHIFT (VALID_SHIFT)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_vec[gi]),
            .glitch_n (glitch_n),
            .valid_m  (valid_m),
            .level_o  (lvl[gi]),
            .rise_o   (rise[gi]),
            .fall_o   (fall[gi])
        );
    end

    // Place the hardware event sources at their pending bit positions.
    always_comb begin
        hw_evt          = '0;
        hw_evt[B_CORE]  = core_irq_in;
        hw_evt[B_HPD_R] = rise[0];
        hw_evt[B_HPD_F] = fall[0];
        hw_evt[B_RXS_R] = rise[1];
        hw_evt[B_RXS_F] = fall[1];
    end

    hpd_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hw_evt    (hw_evt),
        .levels    (lvl),
        .glitch_n  (glitch_n),
        .valid_m   (valid_m),
        .pending   (pending),
        .enable    (enable),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );
endmodule

// File: rtl/hpd_intr_filter_chk.sv
// Module: assertion checker bound into hpd_intr_filter.
// Observes the edge flags, the filtered levels and the register state.
module hpd_intr_filter_chk
    import hpd_intr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              core_irq_in,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [1:0]        lvl,
    input logic [1:0]        rise,
    input logic [1:0]        fall,
    input logic [IRQ_W-1:0]  pending,
    input logic [IRQ_W-1:0]  enable,
    input logic              irq_out
);
    a_r3_level_rise_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl[0]) |-> rise[0]);

    a_r4_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> pending[B_HPD_R]);

    a_r4_no_dual_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise[1] && fall[1]));

    a_r4_fall_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[B_HPD_F] && !(bus_wr && bus_addr == A_CLEAR && bus_wdata[B_HPD_F]))
        |=> pending[B_HPD_F]);

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLEAR && bus_wdata[B_CORE] && !core_irq_in)
        |=> !pending[B_CORE]);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_in |=> pending[B_CORE]);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_out);
endmodule

bind hpd_intr_filter hpd_intr_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_irq_in (core_irq_in),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .lvl         (lvl),
    .rise        (rise),
    .fall        (fall),
    .pending     (pending),
    .enable      (enable),
    .irq_out     (irq_out)
);

// File: tb/test_hpd_intr_filter.sv
// Bench: a table of pulse-width vectors, followed by directed tests for latency,
// masking, receiver sense, the core request, set/clear collisions and readback.
module test_hpd_intr_filter;
    localparam int SHIFT = 2;
    localparam int STEP  = 1 << SHIFT;
    localparam int NVEC  = 10;

    // Each entry is {N, M, width, accept}.
    localparam int VEC [NVEC][4] = '{
        '{0, 0, 1, 1}, '{3, 0, 3, 0}, '{3, 0, 4, 1}, '{0, 2, 8, 0}, '{0, 2, 9, 1},
        '{5, 1, 5, 0}, '{5, 1, 6, 1}, '{2, 3, 12, 0}, '{2, 3, 13, 1}, '{15, 0, 16, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hpd_raw = 1'b0;
    logic        rxsense_raw = 1'b0;
    logic        core_irq_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq_out;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    hpd_intr_filter #(.VALID_SHIFT(SHIFT)) i_hpd_intr_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .hpd_raw     (hpd_raw),
        .rxsense_raw (rxsense_raw),
        .core_irq_in (core_irq_in),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_out     (irq_out)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        rd(3'd0, rv); chk("R1 cfg", rv, 16'h0);
        rd(3'd1, rv); chk("R1 enable", rv, 16'h0);
        rd(3'd2, rv); chk("R1 pending", rv, 16'h0);
        rd(3'd4, rv); chk("R1 level", rv, 16'h0);
        chk("R1 irq", {15'd0, irq_out}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R4 table walk over glitch and persistence bounds
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd0, 16'((VEC[i][0] << 12) | VEC[i][1]));
            @(negedge clk); hpd_raw = 1'b1;
            repeat (VEC[i][2]) @(negedge clk);
            hpd_raw = 1'b0;
            repeat (VEC[i][2] + VEC[i][0] + VEC[i][1] * STEP + 12) @(posedge clk);
            #2;
            rd(3'd2, rv); chk("R2/R3/R4 table pending", rv, (VEC[i][3] != 0) ? 16'h0006 : 16'h0);
            rd(3'd4, rv); chk("R3 table level back low", rv, 16'h0);
            wr(3'd3, 16'h00FF);
        end

        // R3 exact edge: N=1, M=2 -> level changes at edge 4+1+8=13
        wr(3'd0, 16'h1002);
        rd(3'd4, rv);
        @(negedge clk); hpd_raw = 1'b1;
        repeat (12) @(posedge clk); #2;
        rd(3'd4, rv); chk("R3 level before threshold", rv, 16'h0);
        @(posedge clk); #2;
        rd(3'd4, rv); chk("R3 level at threshold", rv, 16'h1);
        @(posedge clk); #2;
        rd(3'd2, rv); chk("R4 hpd rise pending", rv, 16'h0002);

        // R9 enable gating
        chk("R9 irq disabled", {15'd0, irq_out}, 16'h0);
        wr(3'd1, 16'h0002); #1;
        chk("R9 irq enabled", {15'd0, irq_out}, 16'h1);
        wr(3'd1, 16'h0004); #1;
        chk("R9 irq other bit", {15'd0, irq_out}, 16'h0);
        wr(3'd1, 16'hFFFF); rd(3'd1, rv);
        chk("R9 enable readback", rv, 16'h00C7);
        wr(3'd1, 16'h0000);

        // R4 receiver sense edges and sticky flags
        @(negedge clk); rxsense_raw = 1'b1;
        repeat (20) @(posedge clk); #2;
        rd(3'd2, rv); chk("R4 rxsense rise", rv, 16'h0042);
        rd(3'd4, rv); chk("R3 both levels high", rv, 16'h3);
        @(negedge clk); rxsense_raw = 1'b0; hpd_raw = 1'b0;
        repeat (20) @(posedge clk); #2;
        rd(3'd2, rv); chk("R4 falls sticky", rv, 16'h00C6);
        wr(3'd3, 16'h00FF); rd(3'd2, rv);
        chk("R7 clear all", rv, 16'h0);

        // R5 R8 core request and set-over-clear collision
        @(negedge clk); core_irq_in = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 16'h0001;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd2, rv); chk("R8 set beats clear", rv, 16'h0001);
        core_irq_in = 1'b0;
        rd(3'd2, rv); chk("R5 core pending held", rv, 16'h0001);
        wr(3'd3, 16'h0001); rd(3'd2, rv);
        chk("R7 core cleared", rv, 16'h0);

        // R6 R7 software set and clear register readback
        wr(3'd2, 16'hFFFF); rd(3'd2, rv);
        chk("R6 sw set implemented bits", rv, 16'h00C7);
        rd(3'd3, rv); chk("R7 clear reads zero", rv, 16'h0);
        wr(3'd3, 16'h0040); rd(3'd2, rv);
        chk("R7 partial clear", rv, 16'h0087);
        wr(3'd3, 16'h00FF);

        // R10 configuration readback
        wr(3'd0, 16'hA5C3); rd(3'd0, rv);
        chk("R10 cfg readback", rv, 16'hA5C3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule